// File: doc/BRIEF.md
# SMBus Target Engine with Optional Packet Error Check

This block is the bit- and byte-level engine of a management-bus target. It watches SCL and SDA lines that the surrounding logic has already brought into the system clock domain. It pulls SDA low through an open-drain enable and recognises its own 7-bit device address. It supports four transaction shapes: write-byte, write-word, read-byte and read-word. Each one ends at a simple register port that carries a command code, write data with a one-cycle strobe, and read data.

The device address comes from two octal selection digits. The upper digit sets the high three address bits and the lower digit sets the low three. The top address bit is zero. On writes the host may add a CRC-8 packet error check byte after the data, or leave it out. The engine takes both forms. It drops a write whose check byte is wrong and records this in a sticky error flag. On reads the engine always sends a check byte after the data. That byte covers every byte of the transaction: both address bytes, the command and the returned data. The engine works only from SCL edges, so the SCL rate does not change its behaviour.

Top module: `smbus_pec_target`

## Requirements
- R1: An address byte whose upper seven bits equal {1'b0, addr_hi_i, addr_lo_i} is acknowledged by driving SDA low during the ninth SCL clock; any other address byte is not acknowledged.
- R2: After an address that does not match, the engine leaves SDA released for every further byte until the next START or STOP.
- R3: A write of exactly the command's data length (one byte, or two when reg_word_i is high) with no check byte raises reg_wr_o for one cycle just after STOP. The cycle carries the command on reg_cmd_o and the data on reg_wdata_o: first data byte in bits 7:0, second byte in bits 15:8, and bits 15:8 zero for byte writes.
- R4: A write whose data is followed by one extra byte equal to the CRC-8 (polynomial 0x07, initial value 0x00, MSB first, no final inversion) of the address, command and data bytes is accepted exactly as in R3.
- R5: When the extra byte does not match that CRC, there is no write strobe and pec_err_o goes high. The flag stays high until reset, including across later good writes.
- R6: A write that carries fewer data bytes than the command's length is dropped without an error. A write that carries more than length plus one is dropped and sets pec_err_o. Any data byte after the third is not acknowledged.
- R7: After a repeated START with a matching read address, the engine sends the low data byte from reg_rdata_i, then the high byte for word commands, then the CRC-8 computed over write address, command, read address and the data sent.
- R8: When the host does not acknowledge a byte the engine sent, the engine releases SDA for the rest of the transaction. SDA is also released on any STOP.
- R9: The engine changes its SDA drive only while SCL is low, one cycle after it sees SCL fall.
- R10: After reset SDA is released, reg_wr_o is low and pec_err_o is low.
- R11: The same transactions give the same results at two SCL rates that differ by a factor of four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired bus value) |
| addr_hi_i | input | DIGIT_W | High octal digit of the device address |
| addr_lo_i | input | DIGIT_W | Low octal digit of the device address |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_cmd_o | output | 8 | Command code of the current transaction |
| reg_word_i | input | 1 | 1 when the command at reg_cmd_o carries two data bytes |
| reg_rdata_i | input | 16 | Read data for reg_cmd_o, low byte sent first |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 16 | Write data, valid with reg_wr_o |
| pec_err_o | output | 1 | Sticky communication error flag |

## Verification
The assertions assume a well-formed bus. SCL is held low for at least one system clock after every falling edge. SDA never changes from the host side while SCL is high, except at START and STOP. A STOP or START is never signalled while the engine itself holds SDA low. The bench's host tasks meet these assumptions by design. Every host change of SDA or SCL is separated by a whole quarter bit period of several system clocks. Host SDA changes occur only after SCL has been low for that time. STOP and repeated START are issued only after an acknowledge slot in which the engine has already released SDA.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_RX   = 2'd1,
        M_TX   = 2'd2,
        M_SKIP = 2'd3
    } mode_e;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

endpackage

// File: rtl/smbt_line_evt.sv
module smbt_line_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } lvl_t;

    lvl_t lvl_d, lvl_q;

    always_comb begin
        lvl_d     = lvl_q;
        lvl_d.scl = scl_i;
        lvl_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign scl_rise_o = scl_i & ~lvl_q.scl;
    assign scl_fall_o = ~scl_i & lvl_q.scl;
    // SDA edges with SCL held high mark frame boundaries
    assign start_o    = scl_i & lvl_q.scl & lvl_q.sda & ~sda_i;
    assign stop_o     = scl_i & lvl_q.scl & ~lvl_q.sda & sda_i;

endmodule

// File: rtl/smbt_addr_match.sv
module smbt_addr_match #(
    parameter int DIGIT_W = 3
) (
    input  logic [DIGIT_W-1:0] hi_i,
    input  logic [DIGIT_W-1:0] lo_i,
    input  logic [6:0]         addr7_i,
    output logic               match_o
);
    localparam int ADDR_W = 2 * DIGIT_W;
    localparam int PAD_W  = 7 - ADDR_W;

    logic [6:0] own_addr;

    generate
        if (PAD_W > 0) begin : g_pad
            assign own_addr = {{PAD_W{1'b0}}, hi_i, lo_i};
        end else begin : g_nopad
            assign own_addr = {hi_i, lo_i};
        end
    endgenerate

    assign match_o = (addr7_i == own_addr);

endmodule

// File: rtl/smbt_crc8.sv
module smbt_crc8 #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic [7:0] crc_i,
    input  logic [7:0] byte_i,
    output logic [7:0] crc_o
);
    always_comb begin
        logic [7:0] c;
        c = crc_i ^ byte_i;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ POLY) : (c << 1);
        end
        crc_o = c;
    end

endmodule

// File: rtl/smbus_pec_target.sv
module smbus_pec_target
    import smbt_pkg::*;
#(
    parameter int         DIGIT_W  = 3,
    parameter logic [7:0] CRC_POLY = 8'h07,
    parameter logic [7:0] CRC_INIT = 8'h00,
    parameter int         MAX_RX   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [DIGIT_W-1:0] addr_hi_i,
    input  logic [DIGIT_W-1:0] addr_lo_i,
    output logic               sda_oe_o,
    output logic [7:0]         reg_cmd_o,
    input  logic               reg_word_i,
    input  logic [15:0]        reg_rdata_i,
    output logic               reg_wr_o,
    output logic [15:0]        reg_wdata_o,
    output logic               pec_err_o
);
    localparam int                CNT_W   = $clog2(MAX_RX + 2);
    localparam logic [CNT_W-1:0]  CNT_MAX = CNT_W'(MAX_RX);
    localparam logic [CNT_W-1:0]  CNT_OVF = CNT_W'(MAX_RX + 1);

    typedef struct packed {
        mode_e               mode;
        logic [3:0]          bitcnt;
        logic [BYTE_W-1:0]   sr;
        logic [1:0]          idx;
        logic [CNT_W-1:0]    ndata;
        logic [BYTE_W-1:0]   b0;
        logic [BYTE_W-1:0]   b1;
        logic [BYTE_W-1:0]   cmd;
        logic [BYTE_W-1:0]   crc;
        logic                wr_sel;
        logic                tx_next;
        logic                host_ack;
        logic [1:0]          txi;
        logic [WORD_W-1:0]   rdata;
        logic [BYTE_W-1:0]   txb;
        logic [BYTE_W-1:0]   tsh;
        logic                sda_oe;
        logic                wr;
        logic [WORD_W-1:0]   wdata;
        logic                err;
    } st_t;

    st_t d, q;

    logic scl_rise, scl_fall, start_w, stop_w;
    logic addr_hit;
    logic [7:0] crc_byte, crc_upd;
    logic [CNT_W-1:0] wlen;
    logic [1:0] tlen;

    smbt_line_evt u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_w),
        .stop_o     (stop_w)
    );

    smbt_addr_match #(.DIGIT_W(DIGIT_W)) u_match (
        .hi_i    (addr_hi_i),
        .lo_i    (addr_lo_i),
        .addr7_i (q.sr[7:1]),
        .match_o (addr_hit)
    );

    assign crc_byte = (q.mode == M_TX) ? q.txb : q.sr;

    smbt_crc8 #(.POLY(CRC_POLY)) u_crc (
        .crc_i  (q.crc),
        .byte_i (crc_byte),
        .crc_o  (crc_upd)
    );

    assign wlen = reg_word_i ? CNT_W'(2) : CNT_W'(1);
    assign tlen = reg_word_i ? 2'd2 : 2'd1;

    always_comb begin
        logic [7:0] nb;
        logic       ok_plain, ok_pec;
        d        = q;
        d.wr     = 1'b0;
        nb       = '0;
        ok_plain = (q.ndata == wlen);
        ok_pec   = (q.ndata == wlen + CNT_W'(1)) && (q.crc == 8'h00);

        if (start_w) begin
            d.mode    = M_RX;
            d.bitcnt  = '0;
            d.idx     = '0;
            d.ndata   = '0;
            d.sda_oe  = 1'b0;
            d.wr_sel  = 1'b0;
            d.tx_next = 1'b0;
            if (q.mode == M_IDLE) d.crc = CRC_INIT;
        end else if (stop_w) begin
            if (q.mode != M_IDLE && q.wr_sel) begin
                if (ok_plain || ok_pec) begin
                    d.wr    = 1'b1;
                    d.wdata = reg_word_i ? {q.b1, q.b0} : {8'h00, q.b0};
                end else if (q.ndata > wlen) begin
                    d.err = 1'b1;
                end
            end
            d.mode   = M_IDLE;
            d.sda_oe = 1'b0;
            d.wr_sel = 1'b0;
        end else begin
            case (q.mode)
                M_RX: begin
                    if (scl_rise) begin
                        if (q.bitcnt < 4'd8) d.sr = {q.sr[6:0], sda_i};
                        if (q.bitcnt < 4'd9) d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        d.crc = crc_upd;
                        case (q.idx)
                            2'd0: begin
                                if (addr_hit) begin
                                    d.sda_oe  = 1'b1;
                                    d.tx_next = q.sr[0];
                                    d.wr_sel  = ~q.sr[0];
                                    d.idx     = 2'd1;
                                end else begin
                                    d.mode = M_SKIP;
                                end
                            end
                            2'd1: begin
                                d.cmd    = q.sr;
                                d.sda_oe = 1'b1;
                                d.idx    = 2'd2;
                            end
                            default: begin
                                if (q.ndata < CNT_MAX) begin
                                    if (q.ndata == '0) d.b0 = q.sr;
                                    if (q.ndata == CNT_W'(1)) d.b1 = q.sr;
                                    d.ndata  = q.ndata + CNT_W'(1);
                                    d.sda_oe = 1'b1;
                                end else begin
                                    d.ndata = CNT_OVF;
                                    d.mode  = M_SKIP;
                                end
                            end
                        endcase
                    end else if (scl_fall && q.bitcnt == 4'd9) begin
                        d.sda_oe = 1'b0;
                        d.bitcnt = '0;
                        if (q.tx_next) begin
                            d.mode    = M_TX;
                            d.tx_next = 1'b0;
                            d.txi     = '0;
                            d.rdata   = reg_rdata_i;
                            d.txb     = reg_rdata_i[7:0];
                            d.tsh     = reg_rdata_i[7:0];
                            d.sda_oe  = ~reg_rdata_i[7];
                        end
                    end
                end
                M_TX: begin
                    if (scl_rise) begin
                        if (q.bitcnt == 4'd8) d.host_ack = ~sda_i;
                        if (q.bitcnt < 4'd9) d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bitcnt >= 4'd1 && q.bitcnt <= 4'd7) begin
                            d.sda_oe = ~q.tsh[6];
                            d.tsh    = {q.tsh[6:0], 1'b0};
                        end else if (q.bitcnt == 4'd8) begin
                            d.sda_oe = 1'b0;
                            if (q.txi < tlen) d.crc = crc_upd;
                            if (q.txi != 2'd3) d.txi = q.txi + 2'd1;
                        end else if (q.bitcnt == 4'd9) begin
                            d.bitcnt = '0;
                            if (q.host_ack && q.txi <= tlen) begin
                                nb       = (q.txi == tlen) ? q.crc : q.rdata[15:8];
                                d.txb    = nb;
                                d.tsh    = nb;
                                d.sda_oe = ~nb[7];
                            end else begin
                                d.mode = M_SKIP;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{mode: M_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o    = q.sda_oe;
    assign reg_cmd_o   = q.cmd;
    assign reg_wr_o    = q.wr;
    assign reg_wdata_o = q.wdata;
    assign pec_err_o   = q.err;

endmodule

// File: rtl/smbt_chk.sv
module smbt_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic wr,
    input logic err,
    input logic stop_det
);
    AST_WR_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> $past(stop_det)); // R3

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !wr); // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R5

    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !wr); // R5

    AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_i)); // R9

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R8

endmodule

bind smbus_pec_target smbt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe_o),
    .wr       (reg_wr_o),
    .err      (pec_err_o),
    .stop_det (stop_w)
);

// File: tb/sim_smbus_pec_target.sv
`timescale 1ns/1ps
module sim_smbus_pec_target;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_scl = 1'b1, host_sda = 1'b1;
    logic [2:0] pin_hi = 3'd5, pin_lo = 3'd3;
    logic sda_oe, reg_word, reg_wr, pec_err;
    logic [7:0] reg_cmd;
    logic [15:0] reg_rdata, reg_wdata;
    wire sda_w = host_sda & ~sda_oe;

    int nchk = 0, nerr = 0, q = 5, cycles = 0;
    int wr_cnt = 0, viol = 0;
    logic [7:0] wr_cmd;
    logic [15:0] wr_data;
    logic prev_oe = 1'b0, prev_scl = 1'b1;

    always #4 clk = ~clk;

    assign reg_word  = reg_cmd[7];
    assign reg_rdata = {~reg_cmd, reg_cmd ^ 8'h3C};

    smbus_pec_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_w),
        .addr_hi_i(pin_hi), .addr_lo_i(pin_lo), .sda_oe_o(sda_oe),
        .reg_cmd_o(reg_cmd), .reg_word_i(reg_word), .reg_rdata_i(reg_rdata),
        .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata), .pec_err_o(pec_err)
    );

    always @(posedge clk) begin
        cycles++;
        if (rst_n) begin
            if (reg_wr) begin
                wr_cnt++;
                wr_cmd  = reg_cmd;
                wr_data = reg_wdata;
            end
            if (sda_oe !== prev_oe && prev_scl) viol++;
        end
        prev_oe  = sda_oe;
        prev_scl = host_scl;
    end

    function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c ^ b;
        for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hq(); repeat (q) @(negedge clk); endtask
    task automatic bus_start();  host_sda = 1; host_scl = 1; hq(); host_sda = 0; hq(); host_scl = 0; hq(); endtask
    task automatic bus_rstart(); host_sda = 1; hq(); host_scl = 1; hq(); host_sda = 0; hq(); host_scl = 0; hq(); endtask
    task automatic bus_stop();   host_sda = 0; hq(); host_scl = 1; hq(); host_sda = 1; hq(); hq(); endtask
    task automatic tx_bit(input logic b); host_sda = b; hq(); host_scl = 1; hq(); hq(); host_scl = 0; hq(); endtask
    task automatic rx_bit(output logic b); host_sda = 1; hq(); host_scl = 1; hq(); b = sda_w; hq(); host_scl = 0; hq(); endtask

    task automatic tx_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) tx_bit(v[i]);
        rx_bit(b);
        ack = ~b;
    endtask

    task automatic rx_byte(output logic [7:0] v, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin rx_bit(b); v[i] = b; end
        tx_bit(~ack);
    endtask

    // n data bytes from data (first byte in bits 7:0), optional check byte xor flip
    task automatic do_write(input logic [7:0] cmd, input int n, input logic [31:0] data,
                            input bit pec, input logic [7:0] flip, output int acks);
        logic [7:0] c, b;
        logic a;
        acks = 0;
        bus_start();
        tx_byte(8'h56, a); acks += a; c = crc8(8'h00, 8'h56);
        tx_byte(cmd, a);   acks += a; c = crc8(c, cmd);
        for (int i = 0; i < n; i++) begin
            b = data[8*i +: 8];
            tx_byte(b, a); acks += a; c = crc8(c, b);
        end
        if (pec) begin tx_byte(c ^ flip, a); acks += a; end
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] cmd, input bit early_nack,
                           output logic [15:0] data, output logic [7:0] pec,
                           output logic [7:0] exp_pec, output logic [7:0] extra);
        logic a;
        logic [7:0] d0, d1, c, e0, e1;
        e0 = cmd ^ 8'h3C; e1 = ~cmd;
        d1 = 8'h00; pec = 8'h00; extra = 8'h00;
        bus_start();
        tx_byte(8'h56, a); tx_byte(cmd, a);
        bus_rstart();
        tx_byte(8'h57, a);
        c = crc8(crc8(crc8(8'h00, 8'h56), cmd), 8'h57);
        if (early_nack) begin
            rx_byte(d0, 1'b0);
            rx_byte(extra, 1'b0);
        end else begin
            rx_byte(d0, 1'b1); c = crc8(c, e0);
            if (cmd[7]) begin rx_byte(d1, 1'b1); c = crc8(c, e1); end
            rx_byte(pec, 1'b0);
        end
        bus_stop();
        data = {d1, d0};
        exp_pec = c;
    endtask

    initial begin : watchdog
        wait (cycles > 195000);
        nerr++; nchk++;
        $display("FAIL watchdog actual=%0d expected<195000", cycles);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        int acks, w0;
        logic a;
        logic [15:0] rd;
        logic [7:0] p, ep, ex;
        repeat (4) @(negedge clk);
        chk("R10 sda released", sda_oe, 0);
        chk("R10 no strobe", reg_wr, 0);
        chk("R10 err clear", pec_err, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 address sweeps over two pin settings
        for (int s = 0; s < 2; s++) begin
            pin_hi = (s == 0) ? 3'd5 : 3'd0;
            pin_lo = (s == 0) ? 3'd3 : 3'd7;
            for (int ad = 0; ad < 128; ad++) begin
                bus_start();
                tx_byte({ad[6:0], 1'b0}, a);
                bus_stop();
                chk("R1 address ack", a, (ad == {pin_hi, pin_lo}) ? 1 : 0);
            end
        end
        pin_hi = 3'd5; pin_lo = 3'd3;
        chk("R1 no write from address-only frames", wr_cnt, 0);

        // R2 non-matching address: later bytes not acked
        bus_start(); tx_byte(8'h58, a); chk("R2 addr nack", a, 0);
        tx_byte(8'h00, a); chk("R2 byte after miss", a, 0);
        tx_byte(8'h12, a); chk("R2 second byte after miss", a, 0);
        bus_stop();

        for (int sp = 0; sp < 2; sp++) begin
            q = (sp == 0) ? 20 : 5;
            w0 = wr_cnt;
            do_write(8'h12, 1, 32'hA5, 0, 8'h00, acks);
            chk("R3 R11 byte write acks", acks, 3);
            chk("R3 R11 byte write strobe", wr_cnt, w0 + 1);
            chk("R3 byte write cmd", wr_cmd, 8'h12);
            chk("R3 byte write data", wr_data, 16'h00A5);
            do_write(8'h93, 2, 32'h1234, 0, 8'h00, acks);
            chk("R3 word write strobe", wr_cnt, w0 + 2);
            chk("R3 word write data", wr_data, 16'h1234);
            do_write(8'h44, 1, 32'h5E, 1, 8'h00, acks);
            chk("R4 byte write with check acks", acks, 4);
            chk("R4 byte write with check strobe", wr_cnt, w0 + 3);
            chk("R4 byte write with check data", wr_data, 16'h005E);
            do_write(8'hC1, 2, 32'hBEEF, 1, 8'h00, acks);
            chk("R4 word write with check strobe", wr_cnt, w0 + 4);
            chk("R4 word write with check cmd", wr_cmd, 8'hC1);
            chk("R4 word write with check data", wr_data, 16'hBEEF);
            chk("R4 no error", pec_err, 0);

            do_read(8'h21, 0, rd, p, ep, ex);
            chk("R7 R11 read byte data", rd, {8'h00, 8'h21 ^ 8'h3C});
            chk("R7 R11 read byte check", p, ep);
            do_read(8'hA7, 0, rd, p, ep, ex);
            chk("R7 read word data", rd, {~8'hA7, 8'hA7 ^ 8'h3C});
            chk("R7 read word check", p, ep);
            do_read(8'h80, 1, rd, p, ep, ex);
            chk("R8 first byte before nack", rd[7:0], 8'h80 ^ 8'h3C);
            chk("R8 released after nack", ex, 8'hFF);
            chk("R8 idle after stop", sda_oe, 0);

            do_write(8'h90, 1, 32'h77, 0, 8'h00, acks);
            chk("R6 short write dropped", wr_cnt, w0 + 4);
            chk("R6 short write no error", pec_err, 0);
        end

        q = 5;
        w0 = wr_cnt;
        do_write(8'h95, 2, 32'h4321, 1, 8'h01, acks);
        chk("R5 bad check dropped", wr_cnt, w0);
        chk("R5 bad check flags error", pec_err, 1);
        do_write(8'h33, 1, 32'h3C, 1, 8'h00, acks);
        chk("R5 good write after error", wr_cnt, w0 + 1);
        chk("R5 error sticky", pec_err, 1);
        do_write(8'h10, 4, 32'h44332211, 0, 8'h00, acks);
        chk("R6 fourth data byte nacked", acks, 5);
        chk("R6 overlong write dropped", wr_cnt, w0 + 1);

        chk("R9 sda changes only with scl low", viol, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule